// File: doc/BRIEF.md
# Stored Round-Key Expansion Unit

This unit turns a 256-bit seed into a set of fourteen 128-bit round keys and keeps the whole set in a local key store. It uses the 256-bit AES key schedule. A keystream core that runs cipher rounds reads keys from the store by index, in any order. Reading out of order is the reason the keys are precomputed and not produced on the fly: some keys serve as whitening keys and are needed out of sequence.

A set starts from an external 256-bit seed. The seed is two 128-bit halves, and they become keys 1 and 2 of the set. The unit then derives keys 3 to 14 at one 32-bit word per clock. When the keystream core has used up a set, a chained re-key command starts a new one. The last two keys of the old set, key 13 then key 14, become keys 1 and 2 of the new set, and the same schedule runs again. Chaining can repeat for as long as keys are needed. Byte substitution uses an 8-bit S-box. It is computed as the multiplicative inverse in GF(2^8) followed by the affine map.

Top module: `keyx_top`

## Requirements
- R1: After reset, `busy`, `done`, `setReady` and `rdValid` are all low.
- R2: A `loadReq` sampled while the unit is idle starts a new set. Key 1 is `keyIn[255:128]` and key 2 is `keyIn[127:0]`. Inside any key, word 0 sits in bits 127:96.
- R3: Let w[n] be word n of the set, with w[0..7] the seed and key k made of w[4k-4..4k-1]. For n from 8 to 55, w[n] = w[n-8] XOR t. For n mod 8 = 0, t is the S-box applied to each byte of w[n-1] rotated left by one byte, XOR the round constant in the top byte. The constants are 01,02,04,08,10,20 for n/8 = 1..6. For n mod 8 = 4, t is the S-box of each byte of w[n-1]. Otherwise t = w[n-1].
- R4: `busy` is high for exactly 48 cycles after the clock edge that accepts a command. In the first cycle after `busy` falls, `done` is high for exactly one cycle and `setReady` rises.
- R5: A read with `rdEn` high and `rdIdx` in 1..14, issued while idle with a complete set, gives `rdValid` high and the stored key on `rdData` one cycle later.
- R6: `rdValid` stays low for a read issued during expansion, in the same cycle as an accepted command, before any set is complete, or with `rdIdx` of 0 or 15.
- R7: A `rekeyReq` accepted while idle with a complete set makes the new keys 1 and 2 equal the old keys 13 and 14. The new keys 3 to 14 are then derived from them as in R3.
- R8: `rekeyReq` has no effect while no complete set exists, and none while `busy` is high.
- R9: `loadReq` has no effect while `busy` is high. The running expansion completes on its original seed and keeps its 48-cycle length.
- R10: When `loadReq` and `rekeyReq` are both high in one idle cycle, the load is taken and the rekey is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadReq | input | 1 | Start a set from `keyIn` |
| keyIn | input | 256 | External seed: key 1 in the upper half, key 2 in the lower half |
| rekeyReq | input | 1 | Start a chained set from stored keys 13 and 14 |
| rdEn | input | 1 | Read request |
| rdIdx | input | 4 | Key index 1..14 |
| rdData | output | 128 | Key read back, one cycle after the request |
| rdValid | output | 1 | `rdData` holds a valid key |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle pulse when a set completes |
| setReady | output | 1 | A complete key set is stored |

## Verification
Two pairs of functions can meet in one cycle, and the bench provokes both on purpose. In the first, a read request arrives in the same cycle that a load is accepted. The bench raises `rdEn` and `loadReq` on one edge and expects `rdValid` low, because keys 1 and 2 are being overwritten. In the second, `loadReq` and `rekeyReq` are raised together while idle. The bench judges which one was taken by comparing all fourteen stored keys with a reference expansion of the external seed, not with the chained one. Loads and rekeys raised in the middle of an expansion are also checked against the original seed and the 48-cycle busy count.

// File: rtl/keyx_pkg.sv
package keyx_pkg;
  localparam int WORD_W        = 32;
  localparam int SEED_WORDS    = 8;
  localparam int WORDS_PER_KEY = 4;
  localparam int NUM_KEYS      = 14;
  localparam int TOTAL_WORDS   = NUM_KEYS * WORDS_PER_KEY;
  localparam int STEPS         = TOTAL_WORDS - SEED_WORDS;
  localparam int WIDX_W        = $clog2(TOTAL_WORDS);
  localparam int KIDX_W        = $clog2(NUM_KEYS + 1);
  localparam int KEY_W         = WORD_W * WORDS_PER_KEY;
  localparam int SEED_W        = WORD_W * SEED_WORDS;

  typedef enum logic {ST_IDLE, ST_EXPAND} keyxState_t;

  typedef struct packed {
    logic              loadKey;
    logic              loadSeed;
    logic              step;
    logic [WIDX_W-1:0] wordIdx;
  } keyxStrobes_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] t;
    p = 8'h00;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ t;
      t = xtime(t);
    end
    return p;
  endfunction

  // inverse as x^254, then affine map
  function automatic logic [7:0] sboxCalc(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = x;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gfMul(sq, sq);
      acc = gfMul(acc, sq);
    end
    return acc ^ {acc[6:0], acc[7]} ^ {acc[5:0], acc[7:6]} ^
           {acc[4:0], acc[7:5]} ^ {acc[3:0], acc[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] rcon(input logic [WIDX_W-1:0] wordIdx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      if (i < int'(wordIdx / SEED_WORDS)) r = xtime(r);
    end
    return r;
  endfunction
endpackage

// File: rtl/keyx_sbox.sv
module keyx_sbox (
  input  logic [7:0] byteIn,
  output logic [7:0] byteOut
);
  import keyx_pkg::*;
  always_comb byteOut = sboxCalc(byteIn);
endmodule

// File: rtl/keyx_ctrl.sv
module keyx_ctrl
  import keyx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadReq,
  input  logic              rekeyReq,
  input  logic              rdEn,
  input  logic [KIDX_W-1:0] rdIdx,
  output keyxStrobes_t      strobes,
  output logic              busy,
  output logic              done,
  output logic              setReady,
  output logic              rdValid
);
  localparam logic [WIDX_W-1:0] FIRST_IDX = WIDX_W'(SEED_WORDS);
  localparam logic [WIDX_W-1:0] LAST_IDX  = WIDX_W'(TOTAL_WORDS - 1);

  keyxState_t        state;
  logic [WIDX_W-1:0] cnt;
  logic              isIdle;
  logic              doLoad;
  logic              doRekey;
  logic              accept;
  logic              idxOk;

  always_comb begin
    isIdle  = (state == ST_IDLE);
    doLoad  = isIdle && loadReq;
    doRekey = isIdle && rekeyReq && !loadReq && setReady;
    accept  = doLoad || doRekey;
    idxOk   = (rdIdx != '0) && (int'(rdIdx) <= NUM_KEYS);
    strobes.loadKey  = doLoad;
    strobes.loadSeed = doRekey;
    strobes.step     = (state == ST_EXPAND);
    strobes.wordIdx  = cnt;
    busy             = (state == ST_EXPAND);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= FIRST_IDX;
      done     <= 1'b0;
      setReady <= 1'b0;
      rdValid  <= 1'b0;
    end else begin
      rdValid <= rdEn && isIdle && setReady && !accept && idxOk;
      done    <= (state == ST_EXPAND) && (cnt == LAST_IDX);
      if (accept) begin
        state    <= ST_EXPAND;
        cnt      <= FIRST_IDX;
        setReady <= 1'b0;
      end else if (state == ST_EXPAND) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_IDX) begin
          state    <= ST_IDLE;
          setReady <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/keyx_datapath.sv
module keyx_datapath
  import keyx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  keyxStrobes_t      strobes,
  input  logic [SEED_W-1:0] keyIn,
  input  logic              rdEn,
  input  logic [KIDX_W-1:0] rdIdx,
  output logic [KEY_W-1:0]  rdData
);
  localparam int BYTES = WORD_W / 8;

  logic [WORD_W-1:0] mem [TOTAL_WORDS];
  logic [WORD_W-1:0] win [SEED_WORDS];
  logic [WORD_W-1:0] prevWord;
  logic [WORD_W-1:0] subIn;
  logic [WORD_W-1:0] subOut;
  logic [WORD_W-1:0] mixWord;
  logic [WORD_W-1:0] newWord;
  logic              rotPhase;
  logic              subPhase;
  int                baseIdx;

  always_comb begin
    prevWord = win[SEED_WORDS-1];
    rotPhase = (int'(strobes.wordIdx) % SEED_WORDS) == 0;
    subPhase = (int'(strobes.wordIdx) % SEED_WORDS) == SEED_WORDS / 2;
    subIn    = rotPhase ? {prevWord[WORD_W-9:0], prevWord[WORD_W-1 -: 8]} : prevWord;
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_sbox
    keyx_sbox u_sbox (
      .byteIn (subIn[8*b +: 8]),
      .byteOut(subOut[8*b +: 8])
    );
  end

  always_comb begin
    if (rotPhase)      mixWord = subOut ^ {rcon(strobes.wordIdx), {(WORD_W-8){1'b0}}};
    else if (subPhase) mixWord = subOut;
    else               mixWord = prevWord;
    newWord = win[0] ^ mixWord;
  end

  always_ff @(posedge clk) begin
    if (strobes.loadKey) begin
      for (int i = 0; i < SEED_WORDS; i++) begin
        mem[i] <= keyIn[SEED_W-1-WORD_W*i -: WORD_W];
        win[i] <= keyIn[SEED_W-1-WORD_W*i -: WORD_W];
      end
    end else if (strobes.loadSeed) begin
      for (int i = 0; i < SEED_WORDS; i++) begin
        mem[i] <= mem[TOTAL_WORDS-SEED_WORDS+i];
        win[i] <= mem[TOTAL_WORDS-SEED_WORDS+i];
      end
    end else if (strobes.step) begin
      mem[strobes.wordIdx] <= newWord;
      for (int i = 0; i < SEED_WORDS - 1; i++) win[i] <= win[i+1];
      win[SEED_WORDS-1] <= newWord;
    end
  end

  always_comb begin
    if (rdIdx == '0 || int'(rdIdx) > NUM_KEYS) baseIdx = 0;
    else baseIdx = (int'(rdIdx) - 1) * WORDS_PER_KEY;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      for (int i = 0; i < WORDS_PER_KEY; i++)
        rdData[KEY_W-1-WORD_W*i -: WORD_W] <= mem[baseIdx+i];
    end
  end
endmodule

// File: rtl/keyx_top.sv
module keyx_top (
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadReq,
  input  logic [255:0] keyIn,
  input  logic         rekeyReq,
  input  logic         rdEn,
  input  logic [3:0]   rdIdx,
  output logic [127:0] rdData,
  output logic         rdValid,
  output logic         busy,
  output logic         done,
  output logic         setReady
);
  import keyx_pkg::*;

  keyxStrobes_t strobes;

  keyx_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadReq (loadReq),
    .rekeyReq(rekeyReq),
    .rdEn    (rdEn),
    .rdIdx   (rdIdx),
    .strobes (strobes),
    .busy    (busy),
    .done    (done),
    .setReady(setReady),
    .rdValid (rdValid)
  );

  keyx_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .keyIn  (keyIn),
    .rdEn   (rdEn),
    .rdIdx  (rdIdx),
    .rdData (rdData)
  );
endmodule

// File: rtl/keyx_checker.sv
module keyx_checker (
  input logic clk,
  input logic rstN,
  input logic loadReq,
  input logic rekeyReq,
  input logic rdEn,
  input logic busy,
  input logic done,
  input logic setReady,
  input logic rdValid
);
  import keyx_pkg::*;

  int busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= 0;
    else       busyCnt <= busy ? busyCnt + 1 : 0;
  end

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyCnt == STEPS);
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (setReady && !busy));
  p_ready_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !setReady);
  p_load_starts_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadReq) |=> busy);
  p_rekey_no_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !setReady && rekeyReq && !loadReq) |=> !busy);
  p_read_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(rdEn) && !$past(busy) && $past(setReady)));
endmodule

bind keyx_top keyx_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .loadReq (loadReq),
  .rekeyReq(rekeyReq),
  .rdEn    (rdEn),
  .busy    (busy),
  .done    (done),
  .setReady(setReady),
  .rdValid (rdValid)
);

// File: tb/tb_keyx_top.sv
`timescale 1ns/1ps
module tb_keyx_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         loadReq;
  logic [255:0] keyIn;
  logic         rekeyReq;
  logic         rdEn;
  logic [3:0]   rdIdx;
  logic [127:0] rdData;
  logic         rdValid;
  logic         busy;
  logic         done;
  logic         setReady;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;
  logic [7:0]  tbSbox [256];
  logic [31:0] refW [56];

  always #2.5 clk = ~clk;

  keyx_top dut (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .keyIn(keyIn),
    .rekeyReq(rekeyReq), .rdEn(rdEn), .rdIdx(rdIdx), .rdData(rdData),
    .rdValid(rdValid), .busy(busy), .done(done), .setReady(setReady)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // S-box table by walking generator 3 and its inverse
  task automatic buildSbox();
    logic [7:0] p = 8'h01;
    logic [7:0] q = 8'h01;
    logic [7:0] x;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4);
      tbSbox[p] = x ^ 8'h63;
    end while (p != 8'h01);
    tbSbox[0] = 8'h63;
  endtask

  function automatic logic [31:0] subW(input logic [31:0] w);
    return {tbSbox[w[31:24]], tbSbox[w[23:16]], tbSbox[w[15:8]], tbSbox[w[7:0]]};
  endfunction

  task automatic refExpand(input logic [255:0] k);
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 8; i++) refW[i] = k[255-32*i -: 32];
    for (int i = 8; i < 56; i++) begin
      t = refW[i-1];
      if (i % 8 == 0) begin
        t = subW({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
      end else if (i % 8 == 4) begin
        t = subW(t);
      end
      refW[i] = refW[i-8] ^ t;
    end
  endtask

  function automatic logic [127:0] refKey(input int k);
    return {refW[4*k-4], refW[4*k-3], refW[4*k-2], refW[4*k-1]};
  endfunction

  function automatic logic [255:0] chainSeed();
    return {refKey(13), refKey(14)};
  endfunction

  task automatic readKey(input int idx, output logic [127:0] d, output logic v);
    @(negedge clk);
    rdEn = 1'b1;
    rdIdx = 4'(idx);
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
    v = rdValid;
  endtask

  task automatic checkAll(input string req);
    logic [127:0] d;
    logic v;
    for (int k = 1; k <= 14; k++) begin
      readKey(k, d, v);
      check(v && d == refKey(k), req, {v, d[126:0]}, {1'b1, refKey(k)[126:0]});
    end
  endtask

  task automatic waitExpand(output int cycles);
    cycles = 0;
    while (busy) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic runLoad(input logic [255:0] k, input bit alsoRekey, input bit alsoRead,
                         output logic readV);
    int cyc;
    @(negedge clk);
    loadReq = 1'b1;
    keyIn = k;
    rekeyReq = alsoRekey;
    rdEn = alsoRead;
    rdIdx = 4'd1;
    @(negedge clk);
    loadReq = 1'b0;
    rekeyReq = 1'b0;
    rdEn = 1'b0;
    readV = rdValid;
    waitExpand(cyc);
    check(cyc == 48, "R4 busy length", 128'(cyc), 128'd48);
    check(done && setReady, "R4 done and setReady", {done, setReady}, 2'b11);
    @(negedge clk);
    check(!done, "R4 done one cycle", 128'(done), 128'd0);
  endtask

  initial begin
    logic [127:0] d;
    logic v;
    logic [255:0] k;
    int cyc;
    buildSbox();
    rstN = 1'b0; loadReq = 1'b0; rekeyReq = 1'b0; rdEn = 1'b0; rdIdx = '0; keyIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !setReady && !rdValid, "R1 reset state",
          {busy, done, setReady, rdValid}, 0);

    readKey(1, d, v);
    check(!v, "R6 read before any set", 128'(v), 0);
    @(negedge clk);
    rekeyReq = 1'b1;
    @(negedge clk);
    rekeyReq = 1'b0;
    check(!busy, "R8 rekey with no set", 128'(busy), 0);

    // all-zero seed, known-answer on key 3
    refExpand('0);
    runLoad('0, 1'b0, 1'b0, v);
    readKey(3, d, v);
    check(v && d == 128'h62636363626363636263636362636363, "R3 zero-seed key 3", d,
          128'h62636363626363636263636362636363);
    checkAll("R2 R3 R5 zero seed");

    // disturbances during expansion
    k = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
    refExpand(k);
    @(negedge clk);
    loadReq = 1'b1; keyIn = k;
    @(negedge clk);
    loadReq = 1'b0;
    cyc = 0;
    while (busy) begin
      loadReq  = (cyc == 10);
      keyIn    = (cyc == 10) ? ~k : k;
      rekeyReq = (cyc == 20);
      rdEn     = (cyc == 30);
      rdIdx    = 4'd3;
      @(negedge clk);
      cyc++;
      if (cyc == 31) check(!rdValid, "R6 read during expansion", 128'(rdValid), 0);
    end
    loadReq = 1'b0; rekeyReq = 1'b0; rdEn = 1'b0;
    check(cyc == 48, "R9 R8 expansion length kept", 128'(cyc), 128'd48);
    checkAll("R9 R8 original seed kept");

    readKey(0, d, v);
    check(!v, "R6 index 0", 128'(v), 0);
    readKey(15, d, v);
    check(!v, "R6 index 15", 128'(v), 0);

    // chained rekeys
    for (int n = 0; n < 3; n++) begin
      refExpand(chainSeed());
      @(negedge clk);
      rekeyReq = 1'b1;
      @(negedge clk);
      rekeyReq = 1'b0;
      waitExpand(cyc);
      check(cyc == 48 && setReady, "R7 rekey length", 128'(cyc), 128'd48);
      checkAll("R7 chained set");
    end

    // read in accept cycle
    refExpand({256{1'b1}});
    runLoad({256{1'b1}}, 1'b0, 1'b1, v);
    check(!v, "R6 read in accept cycle", 128'(v), 0);
    checkAll("R2 all-ones seed");

    // load and rekey together
    k = {8{32'h0f1e2d3c}} ^ {4{64'h0123456789abcdef}};
    refExpand(k);
    runLoad(k, 1'b1, 1'b0, v);
    checkAll("R10 load wins");

    // arithmetic seed sweep
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 8; i++) k[255-32*i -: 32] = 32'(s * 32'h9e3779b9 + i * 32'h7f4a7c15);
      refExpand(k);
      runLoad(k, 1'b0, 1'b0, v);
      checkAll("R3 R5 seed sweep");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule